// File: doc/BRIEF.md
# Two-Wire EEPROM Target Read Engine

This block is the device side of a two-wire serial EEPROM holding 8192 bytes. It watches SCL and SDA, which it samples in its own clock domain, and it decodes start, repeated start and stop conditions. It answers a control byte only when the byte carries the device code and the chip-select value on its three strap pins. It drives SDA as an open drain: a high output enable pulls the line low.

A single 13-bit word pointer does all the addressing. A write-mode transfer loads the pointer from two address bytes. A read-mode transfer shifts out bytes starting at the pointer, and the pointer advances once after every byte it sends. A dummy write followed by a repeated start is therefore a random read. A read with no address phase first is a current-address read. If the host acknowledges each byte, the read runs on as a sequential read.

Programming is outside this block, so the storage returns a fixed pattern computed from the address. This lets any host or bench predict every byte.

Top module: `twi_eeprom_target`

## Requirements
- R1: A control byte is accepted only if its upper nibble is 4'b1010, bits 3..1 equal `strap_i[2:0]` (bit 3 matching `strap_i[2]`), and bit 0 gives the direction (1 = read, 0 = write). An accepted control byte is acknowledged by holding SDA low through the ninth clock.
- R2: A control byte that fails the match is not acknowledged. Every byte after it, up to the next start condition, is also left unacknowledged and does not change the pointer.
- R3: After a write-mode control byte the target acknowledges an address high byte and then an address low byte. The pointer is loaded with {high[4:0], low}, and high-byte bits 7..5 have no effect.
- R4: A repeated start after the address bytes, followed by a read-mode control byte, returns the byte at the loaded address. No data is written.
- R5: A read-mode transfer with no address phase begins at the pointer. After a read that ended at address n, it returns the byte at n+1.
- R6: When the host acknowledges a data byte, the target sends the byte at the next address. When the host does not acknowledge, the target releases SDA and drives nothing until the next start condition.
- R7: The pointer advances by one after each byte sent, and it wraps from 0x1FFF to 0x0000.
- R8: The byte stored at address a is a[7:0] XOR {3'b000, a[12:8]} XOR 8'h5A. Bytes are sent MSB first.
- R9: The output enable changes only while SCL is low. A start or stop condition ends any transfer in progress, releases SDA, and leaves the pointer as it was.
- R10: After reset SDA is released and the pointer is 0x0000.
- R11: In a write-mode transfer, any byte after the address low byte is not acknowledged and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; it samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired-AND level) |
| strap_i | input | 3 | Chip-select value that the control byte must carry |
| sda_oe_o | output | 1 | High pulls SDA low; low releases the line |

## Verification
The bench runs a sequential read across the top of the array. A pointer that saturates or wraps at the wrong width returns the wrong bytes after 0x1FFF. It also checks that high-byte bits 7..5 are ignored: a design that keeps them would read from an address outside the array. Mismatched control bytes, surplus write bytes and a stop in the middle of an address byte are each followed by a current-address read. That read exposes any design that acknowledged something it should not have or disturbed the pointer. A per-clock monitor watches for any change of the output enable while SCL is high, which a design with a late acknowledge release would produce.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK_GAP,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_NEXT,
    ST_IGNORE
  } tgt_state_e;

  typedef enum logic [1:0] {
    BK_CTRL,
    BK_AHI,
    BK_ALO
  } byte_kind_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
    logic sda;
  } bus_evt_t;

endpackage

// File: rtl/twi_line_monitor.sv
module twi_line_monitor
  import twi_eeprom_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_last;
  logic                   sda_last;
  logic                   scl_now;
  logic                   sda_now;

  assign scl_now = scl_pipe[TOP];
  assign sda_now = sda_pipe[TOP];

  // idle bus level is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_last <= 1'b1;
      sda_last <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_last <= scl_now;
      sda_last <= sda_now;
    end
  end

  // an SDA edge counts as a condition only while SCL held high on both samples
  always_comb begin
    evt_o.start    = scl_now & scl_last & sda_last & ~sda_now;
    evt_o.stop     = scl_now & scl_last & ~sda_last & sda_now;
    evt_o.scl_rise = scl_now & ~scl_last;
    evt_o.scl_fall = ~scl_now & scl_last;
    evt_o.sda      = sda_now;
  end

endmodule

// File: rtl/ee_word_pointer.sv
module ee_word_pointer #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o
);

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_d;

  // natural modulo-2^ADDR_W wrap on the step
  always_comb begin
    ptr_d = ptr_q;
    if (load_i) begin
      ptr_d = load_val_i;
    end else if (step_i) begin
      ptr_d = ptr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/ee_pattern_array.sv
module ee_pattern_array #(
  parameter int         ADDR_W = 13,
  parameter logic [7:0] SEED   = 8'h5A
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        word_o
);

  generate
    if (ADDR_W > 8) begin : g_fold
      logic [7:0] hi_ext;
      assign hi_ext = 8'(addr_i[ADDR_W-1:8]);
      assign word_o = addr_i[7:0] ^ hi_ext ^ SEED;
    end else begin : g_flat
      assign word_o = 8'(addr_i) ^ SEED;
    end
  endgenerate

endmodule

// File: rtl/twi_target_ctrl.sv
module twi_target_ctrl
  import twi_eeprom_pkg::*;
#(
  parameter int         ADDR_W   = 13,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt_i,
  input  logic [2:0]        strap_i,
  input  logic [7:0]        rd_word_i,
  output logic              sda_oe_o,
  output logic              ptr_load_o,
  output logic [ADDR_W-1:0] ptr_load_val_o,
  output logic              ptr_step_o
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  tgt_state_e        state_q, state_d;
  byte_kind_e        kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic              rd_q, rd_d;
  logic              oe_q, oe_d;
  logic              ctrl_match;

  assign ctrl_match = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:1] == strap_i);
  assign ptr_load_val_o = ADDR_W'({hi_q, shreg_q});

  always_comb begin
    state_d    = state_q;
    kind_d     = kind_q;
    cnt_d      = cnt_q;
    shreg_d    = shreg_q;
    hi_d       = hi_q;
    rd_d       = rd_q;
    oe_d       = oe_q;
    ptr_load_o = 1'b0;
    ptr_step_o = 1'b0;

    if (evt_i.start) begin
      state_d = ST_RECV;
      kind_d  = BK_CTRL;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (evt_i.stop) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_RECV: begin
          if (evt_i.scl_rise) begin
            shreg_d = {shreg_q[BYTE_W-2:0], evt_i.sda};
            if (cnt_q == LAST_BIT) begin
              cnt_d   = '0;
              state_d = ST_ACK_GAP;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end

        ST_ACK_GAP: begin
          if (evt_i.scl_fall) begin
            case (kind_q)
              BK_CTRL: begin
                if (ctrl_match) begin
                  oe_d    = 1'b1;
                  rd_d    = shreg_q[0];
                  state_d = ST_ACK;
                end else begin
                  state_d = ST_IGNORE;
                end
              end
              BK_AHI: begin
                hi_d    = shreg_q;
                oe_d    = 1'b1;
                state_d = ST_ACK;
              end
              BK_ALO: begin
                ptr_load_o = 1'b1;
                oe_d       = 1'b1;
                state_d    = ST_ACK;
              end
              default: state_d = ST_IGNORE;
            endcase
          end
        end

        ST_ACK: begin
          if (evt_i.scl_fall) begin
            oe_d = 1'b0;
            cnt_d = '0;
            case (kind_q)
              BK_CTRL: begin
                if (rd_q) begin
                  shreg_d = rd_word_i;
                  oe_d    = ~rd_word_i[BYTE_W-1];
                  state_d = ST_SEND;
                end else begin
                  kind_d  = BK_AHI;
                  state_d = ST_RECV;
                end
              end
              BK_AHI: begin
                kind_d  = BK_ALO;
                state_d = ST_RECV;
              end
              default: state_d = ST_IGNORE;
            endcase
          end
        end

        ST_SEND: begin
          if (evt_i.scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              oe_d    = 1'b0;
              state_d = ST_MACK;
            end else begin
              shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
              oe_d    = ~shreg_q[BYTE_W-2];
              cnt_d   = cnt_q + CNT_W'(1);
            end
          end
        end

        ST_MACK: begin
          if (evt_i.scl_rise) begin
            ptr_step_o = 1'b1;
            state_d    = evt_i.sda ? ST_IGNORE : ST_NEXT;
          end
        end

        ST_NEXT: begin
          if (evt_i.scl_fall) begin
            shreg_d = rd_word_i;
            oe_d    = ~rd_word_i[BYTE_W-1];
            cnt_d   = '0;
            state_d = ST_SEND;
          end
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= BK_CTRL;
      cnt_q   <= '0;
      shreg_q <= '0;
      hi_q    <= '0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      hi_q    <= hi_d;
      rd_q    <= rd_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe_o = oe_q;

endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
  import twi_eeprom_pkg::*;
#(
  parameter int         ADDR_W      = 13,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter logic [7:0] SEED        = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  bus_evt_t          bus_evt;
  logic [ADDR_W-1:0] word_ptr;
  logic [ADDR_W-1:0] ptr_load_val;
  logic              ptr_load;
  logic              ptr_step;
  logic [7:0]        rd_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  twi_line_monitor #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_mon (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (bus_evt)
  );

  twi_target_ctrl #(
    .ADDR_W   (ADDR_W),
    .DEV_CODE (DEV_CODE)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .evt_i          (bus_evt),
    .strap_i        (strap_i),
    .rd_word_i      (rd_word),
    .sda_oe_o       (sda_oe_o),
    .ptr_load_o     (ptr_load),
    .ptr_load_val_o (ptr_load_val),
    .ptr_step_o     (ptr_step)
  );

  ee_word_pointer #(
    .ADDR_W(ADDR_W)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (ptr_load),
    .load_val_i (ptr_load_val),
    .step_i     (ptr_step),
    .ptr_o      (word_ptr)
  );

  ee_pattern_array #(
    .ADDR_W (ADDR_W),
    .SEED   (SEED)
  ) u_array (
    .addr_i (word_ptr),
    .word_o (rd_word)
  );

endmodule

// File: rtl/twi_eeprom_target_chk.sv
module twi_eeprom_target_chk
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe_i,
  input bus_evt_t          evt_i,
  input logic [ADDR_W-1:0] ptr_i,
  input logic              ptr_load_i,
  input logic [ADDR_W-1:0] ptr_load_val_i,
  input logic              ptr_step_i
);

  // R9: the open-drain enable moves only in the SCL low phase
  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_i) |-> !scl_i);

  // R9: a start or stop leaves the line released
  a_r9_release_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.start || evt_i.stop) |=> !sda_oe_i);

  // R7: a step moves the pointer by exactly one, modulo the array size
  a_r7_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step_i && !ptr_load_i) |=> (ptr_i == ADDR_W'($past(ptr_i) + 1'b1)));

  // R7: without a load or step the pointer holds
  a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_step_i && !ptr_load_i) |=> $stable(ptr_i));

  // R3: a load places the assembled address into the pointer
  a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load_i |=> (ptr_i == $past(ptr_load_val_i)));

endmodule

bind twi_eeprom_target twi_eeprom_target_chk #(
  .ADDR_W(ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .scl_i          (scl_i),
  .sda_oe_i       (sda_oe_o),
  .evt_i          (bus_evt),
  .ptr_i          (word_ptr),
  .ptr_load_i     (ptr_load),
  .ptr_load_val_i (ptr_load_val),
  .ptr_step_i     (ptr_step)
);

// File: tb/twi_eeprom_target_tb_top.sv
module twi_eeprom_target_tb_top;

  localparam int         HALF  = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic scl_m;
  logic sda_m;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  twi_eeprom_target dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .strap_i  (STRAP),
    .sda_oe_o (sda_oe)
  );

  int checks = 0;
  int fails  = 0;
  int ref_ptr = 0;
  int oe_high_moves = 0;
  bit done = 1'b0;

  // reference content from R8
  function automatic logic [7:0] exp_word(input int a);
    logic [12:0] x;
    x = 13'(a);
    return x[7:0] ^ {3'b000, x[12:8]} ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock watch for R9: enable must hold while SCL stays high
  logic prev_scl, prev_oe;
  always @(posedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) oe_high_moves++;
    prev_scl <= scl_m;
    prev_oe  <= sda_oe;
  end

  task automatic slot(input logic m, output logic seen);
    wait_clks(2);
    sda_m = m;
    wait_clks(HALF - 2);
    scl_m = 1'b1;
    wait_clks(HALF / 2);
    seen = sda_bus;
    wait_clks(HALF / 2);
    scl_m = 1'b0;
  endtask

  task automatic start_c();
    wait_clks(2);
    sda_m = 1'b1;
    wait_clks(HALF - 2);
    scl_m = 1'b1;
    wait_clks(HALF / 2);
    sda_m = 1'b0;
    wait_clks(HALF / 2);
    scl_m = 1'b0;
  endtask

  task automatic stop_c();
    wait_clks(2);
    sda_m = 1'b0;
    wait_clks(HALF - 2);
    scl_m = 1'b1;
    wait_clks(HALF / 2);
    sda_m = 1'b1;
    wait_clks(HALF / 2);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) slot(b[i], s);
    slot(1'b1, s);
    check(s == !exp_ack, req, {15'd0, s}, {15'd0, !exp_ack});
  endtask

  task automatic read_byte(input bit host_ack, input string req);
    logic s;
    logic [7:0] got;
    logic [7:0] exp;
    exp = exp_word(ref_ptr);
    for (int i = 7; i >= 0; i--) begin
      slot(1'b1, s);
      got[i] = s;
    end
    check(got == exp, req, {8'd0, got}, {8'd0, exp});
    slot(!host_ack, s);
    ref_ptr = (ref_ptr + 1) & 32'h1FFF;
  endtask

  task automatic current_read(input int n, input string req);
    start_c();
    send_byte({4'hA, STRAP, 1'b1}, 1'b1, "R1 read control ack");
    for (int k = 0; k < n; k++) read_byte(k != n - 1, req);
    stop_c();
  endtask

  task automatic set_addr(input int a, input logic [2:0] junk);
    start_c();
    send_byte({4'hA, STRAP, 1'b0}, 1'b1, "R1 write control ack");
    send_byte({junk, 5'(a >> 8)}, 1'b1, "R3 high address ack");
    send_byte(8'(a), 1'b1, "R3 low address ack");
    ref_ptr = a & 32'h1FFF;
  endtask

  initial begin
    logic s;
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    wait_clks(5);
    check(sda_oe == 1'b0, "R10 released in reset", {15'd0, sda_oe}, 16'd0);
    rst_n = 1'b1;
    wait_clks(5);
    check(sda_oe == 1'b0, "R10 released after reset", {15'd0, sda_oe}, 16'd0);

    // R10 / R5: first current read comes from 0x0000, then 0x0001
    current_read(1, "R10 first read at zero");
    current_read(1, "R5 current read n+1");

    // R3 / R4: random read; top bits of high byte are junk
    set_addr(32'h0ABC, 3'b111);
    start_c();
    send_byte({4'hA, STRAP, 1'b1}, 1'b1, "R4 read control after repeated start");
    read_byte(1'b0, "R4 random read data");
    wait_clks(6);
    check(sda_oe == 1'b0, "R6 release after host nack", {15'd0, sda_oe}, 16'd0);
    slot(1'b1, s);
    check(s == 1'b1, "R6 no drive after nack", {15'd0, s}, 16'd1);
    stop_c();
    current_read(1, "R5 read after random read");

    // R7: sequential read through the wrap point
    set_addr(32'h1FFE, 3'b000);
    start_c();
    send_byte({4'hA, STRAP, 1'b1}, 1'b1, "R6 read control");
    for (int k = 0; k < 4; k++) read_byte(k != 3, "R7 sequential across wrap");
    stop_c();
    current_read(1, "R7 pointer after wrap");

    // R2: wrong chip select, following bytes ignored
    start_c();
    send_byte({4'hA, STRAP ^ 3'b010, 1'b0}, 1'b0, "R2 select mismatch nack");
    send_byte(8'h00, 1'b0, "R2 later byte ignored");
    send_byte(8'h10, 1'b0, "R2 later byte ignored");
    stop_c();
    current_read(1, "R2 pointer untouched");

    // R1: wrong fixed code
    start_c();
    send_byte({4'hB, STRAP, 1'b1}, 1'b0, "R1 code mismatch nack");
    slot(1'b1, s);
    check(s == 1'b1, "R1 no data after mismatch", {15'd0, s}, 16'd1);
    stop_c();
    current_read(1, "R1 pointer untouched");

    // R11: surplus write byte
    set_addr(32'h0123, 3'b010);
    send_byte(8'h77, 1'b0, "R11 surplus byte nack");
    stop_c();
    current_read(1, "R11 pointer from address bytes");

    // R9: stop in the middle of an address byte
    start_c();
    send_byte({4'hA, STRAP, 1'b0}, 1'b1, "R9 write control ack");
    send_byte(8'h05, 1'b1, "R9 high address ack");
    slot(1'b0, s);
    slot(1'b1, s);
    slot(1'b0, s);
    stop_c();
    current_read(2, "R9 pointer kept after abort");

    check(oe_high_moves == 0, "R9 enable stable while SCL high",
          16'(oe_high_moves), 16'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule